// File: doc/BRIEF.md
# Framed Serial Converter Port Master

This block is the host-side master for the serial port of a multi-channel sampling converter. It generates the serial clock and two separate active-low frame strobes, one for writing and one for reading. The write frame shifts a control word, which carries the channel select bits among its fields, out on the host-to-converter data line. The read frame shifts a conversion result in from the converter-to-host data line. The converter launches each read bit after a rising serial clock edge, and the master samples on the falling edge.

A sequencer presents a control word and an operation code, then pulses a start request. The master returns the received word with a one-cycle done pulse and holds busy high for the whole transaction. Every timing interval is counted in system clock cycles and set by parameters: the serial clock half period, the lead time from a strobe falling to the first falling clock edge, and the trail time before the strobe rises. A combined operation runs a write frame, waits a programmable gap, then runs a read frame. Conversion timing is left to the outer sequencer.

Top module: `sadc_frame_master`

## Requirements
- R1: While reset is held and just after it, sclk, txFrameN and rxFrameN are high, busy, done and dataToAdc are low, and rxWord is zero.
- R2: opMode selects the frames run on an accepted request. 2'b00 runs one write frame only, 2'b01 runs one read frame only, and 2'b10 or 2'b11 runs a write frame followed by a read frame.
- R3: In a write frame, dataToAdc carries the ctrlWord captured at the accepted request, MSB first, one bit per falling sclk edge for WORD_W edges. dataToAdc changes only together with a rising sclk edge, so it is stable at every falling edge.
- R4: In a read frame, dataFromAdc is sampled at each of the WORD_W falling sclk edges, MSB first, and the assembled word appears on rxWord together with done. A transaction with no read frame leaves rxWord unchanged.
- R5: A frame strobe falls exactly LEAD_CYC cycles before the first falling sclk edge of its frame. Inside a frame, every sclk low phase and every high phase between falling edges lasts exactly HALF_CYC cycles.
- R6: A frame strobe rises exactly HALF_CYC+TRAIL_CYC cycles after the last falling sclk edge of its frame.
- R7: txFrameN and rxFrameN are never low together, and sclk is high whenever both strobes are high.
- R8: In a combined operation, rxFrameN falls exactly gapCycles+1 cycles after txFrameN rises.
- R9: busy goes high the cycle after an accepted request and falls in the same cycle as the single-cycle done pulse. done coincides with the rise of the final strobe. A request made while busy starts no frame and produces no extra done.
- R10: dataToAdc is low whenever txFrameN is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start a transaction (sampled when not busy) |
| opMode | input | 2 | 00 write, 01 read, 1x write then read |
| gapCycles | input | GAP_W | Idle gap between frames in a combined operation |
| ctrlWord | input | WORD_W | Control word to send, MSB first |
| busy | output | 1 | High while a transaction is in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| rxWord | output | WORD_W | Last word received in a read frame |
| sclk | output | 1 | Serial clock, idles high |
| txFrameN | output | 1 | Active-low write frame strobe |
| rxFrameN | output | 1 | Active-low read frame strobe |
| dataToAdc | output | 1 | Serial data toward the converter |
| dataFromAdc | input | 1 | Serial data from the converter |

## Verification
The hardest situation to reach from the ports is a start request that arrives in the middle of a frame, because it must disappear without leaving a trace. The bench raises startReq with a different opMode partway through a frame, then counts strobe falls and done pulses for a long quiet interval after the transaction ends. The boundaries between frames are also hard to reach: the hand-off from write strobe to read strobe with a zero gap, and the last-bit-to-strobe-rise spacing. These are covered by directed combined operations with gap values 0 and 7, and by a monitor that measures every interval in cycles. That monitor runs alongside random operations, words and gaps.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic clearTx;
    logic sampleRx;
    logic captureRx;
  } dpCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TRAIL,
    ST_GAP
  } frameState_t;

endpackage

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int HALF_CYC  = 7,
  parameter int LEAD_CYC  = 8,
  parameter int TRAIL_CYC = 8,
  parameter int GAP_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [1:0]       opMode,
  input  logic [GAP_W-1:0] gapCycles,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             txFrameN,
  output logic             rxFrameN,
  output dpCtrl_t          dp
);

  localparam int MAX_A  = (LEAD_CYC > TRAIL_CYC) ? LEAD_CYC : TRAIL_CYC;
  localparam int MAX_B  = (MAX_A > HALF_CYC) ? MAX_A : HALF_CYC;
  localparam int GAP_MX = (2 ** GAP_W) - 1;
  localparam int MAX_C  = (MAX_B > GAP_MX) ? MAX_B : GAP_MX;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  frameState_t      state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [BIT_W-1:0] bitCnt, bitNxt;
  logic [GAP_W-1:0] gapReg, gapNxt;
  logic             combo, comboNxt;
  logic             inRx, inRxNxt;
  logic             sclkNxt, txNxt, rxNxt, busyNxt, doneNxt;
  logic             cntZero, lastBit;

  assign cntZero = (cnt == '0);
  assign lastBit = (bitCnt == BIT_W'(WORD_W - 1));

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    bitNxt   = bitCnt;
    gapNxt   = gapReg;
    comboNxt = combo;
    inRxNxt  = inRx;
    sclkNxt  = sclk;
    txNxt    = txFrameN;
    rxNxt    = rxFrameN;
    busyNxt  = busy;
    doneNxt  = 1'b0;
    dp       = '0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          busyNxt  = 1'b1;
          comboNxt = opMode[1];
          gapNxt   = gapCycles;
          bitNxt   = '0;
          cntNxt   = CNT_W'(LEAD_CYC - 1);
          stateNxt = ST_LEAD;
          if (!opMode[1] && opMode[0]) begin
            inRxNxt = 1'b1;
            rxNxt   = 1'b0;
          end else begin
            inRxNxt   = 1'b0;
            txNxt     = 1'b0;
            dp.loadTx = 1'b1;
          end
        end
      end
      ST_LEAD, ST_HIGH: begin
        if (cntZero) begin
          sclkNxt     = 1'b0;
          dp.sampleRx = inRx;
          cntNxt      = CNT_W'(HALF_CYC - 1);
          stateNxt    = ST_LOW;
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      ST_LOW: begin
        if (cntZero) begin
          sclkNxt = 1'b1;
          if (lastBit) begin
            cntNxt   = CNT_W'(TRAIL_CYC - 1);
            stateNxt = ST_TRAIL;
          end else begin
            bitNxt     = bitCnt + BIT_W'(1);
            dp.shiftTx = !inRx;
            cntNxt     = CNT_W'(HALF_CYC - 1);
            stateNxt   = ST_HIGH;
          end
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      ST_TRAIL: begin
        if (cntZero) begin
          txNxt      = 1'b1;
          rxNxt      = 1'b1;
          dp.clearTx = !inRx;
          if (!inRx && combo) begin
            cntNxt   = CNT_W'(gapReg);
            stateNxt = ST_GAP;
          end else begin
            dp.captureRx = inRx;
            doneNxt      = 1'b1;
            busyNxt      = 1'b0;
            stateNxt     = ST_IDLE;
          end
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      ST_GAP: begin
        if (cntZero) begin
          rxNxt    = 1'b0;
          inRxNxt  = 1'b1;
          bitNxt   = '0;
          cntNxt   = CNT_W'(LEAD_CYC - 1);
          stateNxt = ST_LEAD;
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitCnt   <= '0;
      gapReg   <= '0;
      combo    <= 1'b0;
      inRx     <= 1'b0;
      sclk     <= 1'b1;
      txFrameN <= 1'b1;
      rxFrameN <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      state    <= stateNxt;
      cnt      <= cntNxt;
      bitCnt   <= bitNxt;
      gapReg   <= gapNxt;
      combo    <= comboNxt;
      inRx     <= inRxNxt;
      sclk     <= sclkNxt;
      txFrameN <= txNxt;
      rxFrameN <= rxNxt;
      busy     <= busyNxt;
      done     <= doneNxt;
    end
  end

  AST_FRAMES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(!txFrameN && !rxFrameN)); // R7
  AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (txFrameN && rxFrameN) |-> sclk); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (!txFrameN || !rxFrameN) |-> busy); // R9
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && txFrameN && rxFrameN)); // R9

endmodule

// File: rtl/sadc_datapath.sv
module sadc_datapath
  import sadc_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dp,
  input  logic [WORD_W-1:0] ctrlWord,
  input  logic              dataFromAdc,
  output logic              dataToAdc,
  output logic [WORD_W-1:0] rxWord
);

  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (dp.loadTx) begin
      txShift <= ctrlWord;
    end else if (dp.clearTx) begin
      txShift <= '0;
    end else if (dp.shiftTx) begin
      txShift <= {txShift[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxWord  <= '0;
    end else begin
      if (dp.sampleRx) rxShift <= {rxShift[WORD_W-2:0], dataFromAdc};
      if (dp.captureRx) rxWord <= rxShift;
    end
  end

  assign dataToAdc = txShift[WORD_W-1];

  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    dp.loadTx |-> !(dp.shiftTx || dp.clearTx)); // R3
  AST_RX_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !dp.captureRx |=> $stable(rxWord)); // R4

endmodule

// File: rtl/sadc_frame_master.sv
module sadc_frame_master
  import sadc_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int HALF_CYC  = 7,
  parameter int LEAD_CYC  = 8,
  parameter int TRAIL_CYC = 8,
  parameter int GAP_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [1:0]        opMode,
  input  logic [GAP_W-1:0]  gapCycles,
  input  logic [WORD_W-1:0] ctrlWord,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rxWord,
  output logic              sclk,
  output logic              txFrameN,
  output logic              rxFrameN,
  output logic              dataToAdc,
  input  logic              dataFromAdc
);

  dpCtrl_t dpCtl;

  sadc_ctrl #(
    .WORD_W(WORD_W), .HALF_CYC(HALF_CYC), .LEAD_CYC(LEAD_CYC),
    .TRAIL_CYC(TRAIL_CYC), .GAP_W(GAP_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opMode(opMode),
    .gapCycles(gapCycles), .busy(busy), .done(done), .sclk(sclk),
    .txFrameN(txFrameN), .rxFrameN(rxFrameN), .dp(dpCtl)
  );

  sadc_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .dp(dpCtl), .ctrlWord(ctrlWord),
    .dataFromAdc(dataFromAdc), .dataToAdc(dataToAdc), .rxWord(rxWord)
  );

  AST_TX_STABLE_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (!txFrameN && $fell(sclk)) |-> $stable(dataToAdc)); // R3
  AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    txFrameN |-> !dataToAdc); // R10

endmodule

// File: tb/test_sadc_frame_master.sv
`timescale 1ns/1ps
module test_sadc_frame_master;

  localparam int W     = 12;
  localparam int HALF  = 7;
  localparam int LEAD  = 8;
  localparam int TRAIL = 8;
  localparam int GW    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [1:0] opMode = 2'b00;
  logic [GW-1:0] gapCycles = '0;
  logic [W-1:0] ctrlWord = '0;
  logic busy, done, sclk, txFrameN, rxFrameN, dataToAdc;
  logic [W-1:0] rxWord;
  logic dataFromAdc;

  always #2 clk = ~clk;

  sadc_frame_master #(.WORD_W(W), .HALF_CYC(HALF), .LEAD_CYC(LEAD),
                      .TRAIL_CYC(TRAIL), .GAP_W(GW)) i_sadc_frame_master (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opMode(opMode),
    .gapCycles(gapCycles), .ctrlWord(ctrlWord), .busy(busy), .done(done),
    .rxWord(rxWord), .sclk(sclk), .txFrameN(txFrameN), .rxFrameN(rxFrameN),
    .dataToAdc(dataToAdc), .dataFromAdc(dataFromAdc)
  );

  int testsRun = 0;
  int failCnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // converter model: result launched after each rising sclk
  logic [W-1:0] adcVal = '0;
  logic [W-1:0] devShift = '0;
  always @(negedge rxFrameN) devShift = adcVal;
  always @(posedge sclk) if (!rxFrameN) devShift = {devShift[W-2:0], 1'b0};
  assign dataFromAdc = devShift[W-1];

  // control word receiver: samples on falling sclk
  logic [W-1:0] rcvd = '0;
  int rcvBits = 0;
  always @(negedge sclk) if (!txFrameN) begin
    rcvd = {rcvd[W-2:0], dataToAdc};
    rcvBits++;
  end

  // interval monitor, counts in system cycles
  int sinceStrobe = 0, sinceFall = 0, phaseLen = 0, gapLen = 0;
  int vLead = 0, vPhase = 0, vTrail = 0, vIdle = 0, vData = 0;
  int txStarts = 0, rxStarts = 0, doneCount = 0, measuredGap = 0;
  bit firstPend = 0, gapTrack = 0;
  logic prevSclk = 1'b1, prevTx = 1'b1, prevRx = 1'b1;

  always @(negedge clk) if (rstN) begin
    sinceStrobe++; sinceFall++; phaseLen++; gapLen++;
    if (!txFrameN && !rxFrameN) vIdle++;
    if (txFrameN && rxFrameN && !sclk) vIdle++;
    if (txFrameN && dataToAdc) vData++;
    if (done) doneCount++;
    if (prevTx && !txFrameN) begin txStarts++; sinceStrobe = 0; firstPend = 1; end
    if (prevRx && !rxFrameN) begin
      rxStarts++; sinceStrobe = 0; firstPend = 1;
      if (gapTrack) begin measuredGap = gapLen; gapTrack = 0; end
    end
    if (prevSclk && !sclk) begin
      if (firstPend) begin
        if (sinceStrobe != LEAD) vLead++;
        firstPend = 0;
      end else if (phaseLen != HALF) vPhase++;
      phaseLen = 0; sinceFall = 0;
    end
    if (!prevSclk && sclk) begin
      if (phaseLen != HALF) vPhase++;
      phaseLen = 0;
    end
    if ((!prevTx && txFrameN) || (!prevRx && rxFrameN))
      if (sinceFall != HALF + TRAIL) vTrail++;
    if (!prevTx && txFrameN) begin gapTrack = 1; gapLen = 0; end
    prevSclk = sclk; prevTx = txFrameN; prevRx = rxFrameN;
  end

  // expected-value functions from the requirements
  function automatic int expTxFrames(input logic [1:0] m);
    return (m != 2'b01) ? 1 : 0;
  endfunction
  function automatic int expRxFrames(input logic [1:0] m);
    return (m != 2'b00) ? 1 : 0;
  endfunction
  function automatic logic [W-1:0] expRx(input logic [1:0] m, input logic [W-1:0] adc,
                                         input logic [W-1:0] prev);
    return (expRxFrames(m) != 0) ? adc : prev;
  endfunction

  logic [W-1:0] modelRx = '0;

  task automatic runTxn(input logic [1:0] m, input logic [W-1:0] cw,
                        input logic [GW-1:0] g, input logic [W-1:0] adc, input bit poke);
    int bTx, bRx, bDone, bLead, bPhase, bTrail, bIdle, bData, n;
    @(negedge clk);
    adcVal = adc; rcvBits = 0; rcvd = '0; measuredGap = -1;
    bTx = txStarts; bRx = rxStarts; bDone = doneCount;
    bLead = vLead; bPhase = vPhase; bTrail = vTrail; bIdle = vIdle; bData = vData;
    opMode = m; ctrlWord = cw; gapCycles = g; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    ctrlWord = ~cw;
    check(busy === 1'b1, "R9", "busy after request", 32'(busy), 32'd1);
    if (poke) begin
      repeat (40) @(negedge clk);
      opMode = 2'b10; startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    n = 0;
    while (done !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    check(done === 1'b1, "R9", "done reached", 32'(done), 32'd1);
    check(busy === 1'b0, "R9", "busy falls with done", 32'(busy), 32'd0);
    check(rxWord === expRx(m, adc, modelRx), "R4", "rxWord", 32'(rxWord),
          32'(expRx(m, adc, modelRx)));
    modelRx = expRx(m, adc, modelRx);
    @(negedge clk);
    check(done === 1'b0, "R9", "done one cycle", 32'(done), 32'd0);
    repeat (40) @(negedge clk);
    check(txStarts - bTx == expTxFrames(m), "R2", "write frames", 32'(txStarts - bTx),
          32'(expTxFrames(m)));
    check(rxStarts - bRx == expRxFrames(m), "R2", "read frames", 32'(rxStarts - bRx),
          32'(expRxFrames(m)));
    check(doneCount - bDone == 1, "R9", "done count", 32'(doneCount - bDone), 32'd1);
    if (expTxFrames(m) != 0) begin
      check(rcvBits == W, "R3", "bits sent", 32'(rcvBits), 32'(W));
      check(rcvd === cw, "R3", "word sent", 32'(rcvd), 32'(cw));
    end
    if (m[1]) check(measuredGap == int'(g) + 1, "R8", "frame gap", 32'(measuredGap),
                    32'(int'(g) + 1));
    check(vLead == bLead, "R5", "lead violations", 32'(vLead - bLead), 32'd0);
    check(vPhase == bPhase, "R5", "phase violations", 32'(vPhase - bPhase), 32'd0);
    check(vTrail == bTrail, "R6", "trail violations", 32'(vTrail - bTrail), 32'd0);
    check(vIdle == bIdle, "R7", "idle/overlap violations", 32'(vIdle - bIdle), 32'd0);
    check(vData == bData, "R10", "data outside frame", 32'(vData - bData), 32'd0);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      failCnt++;
      testsRun++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
      $display("  [TB] %0d tests run, %0d failed", testsRun, failCnt);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sclk === 1'b1 && txFrameN === 1'b1 && rxFrameN === 1'b1, "R1",
          "idle lines in reset", {29'd0, sclk, txFrameN, rxFrameN}, 32'd7);
    check(busy === 1'b0 && done === 1'b0 && dataToAdc === 1'b0, "R1",
          "flags in reset", {29'd0, busy, done, dataToAdc}, 32'd0);
    check(rxWord === '0, "R1", "rxWord in reset", 32'(rxWord), 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(sclk === 1'b1 && busy === 1'b0, "R1", "idle after reset",
          {30'd0, sclk, busy}, 32'd2);

    runTxn(2'b00, 12'hA5C, 8'd0, 12'h123, 0);
    runTxn(2'b01, 12'h000, 8'd0, 12'hFFF, 0);
    runTxn(2'b01, 12'hFFF, 8'd0, 12'h000, 0);
    runTxn(2'b01, 12'h000, 8'd0, 12'h801, 0);
    runTxn(2'b00, 12'hFFF, 8'd0, 12'h555, 0);
    runTxn(2'b10, 12'h5A1, 8'd0, 12'h3C3, 0);
    runTxn(2'b11, 12'h801, 8'd7, 12'hC3C, 0);
    runTxn(2'b00, 12'h0F0, 8'd2, 12'h777, 1);
    runTxn(2'b01, 12'h000, 8'd2, 12'hABC, 1);
    for (int i = 0; i < 24; i++) begin
      runTxn(2'($urandom % 4), W'($urandom), GW'($urandom % 6), W'($urandom), 0);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, failCnt);
    $finish;
  end

endmodule